// File: doc/BRIEF.md
# Multi-Acceptance Output Arbiter

This block sits in front of the output buffers of a switch that queues cells at both its inputs and its outputs. In each cell slot every input offers at most its head-of-line cell, tagged with a destination output. Each output can write up to `L_ACC` cells into its buffer per slot. The arbiter picks which of the competing inputs get those places. An input that wants a full output is refused for this slot. It keeps its cell at the head of its queue and offers it again later, so the cell is not dropped.

Each output has its own rotating start pointer, and selection is round-robin from that pointer. A granted input also gets a lane number that names the write port of the output buffer it must use. Lanes are numbered in the order in which inputs are reached from the pointer. Each output also reports how many cells it took. All results are registered and appear for one cycle, the cycle after the slot strobe.

Top module: `sw_arb_top`

## Requirements
- R1: In any slot, no output grants more than `L_ACC` inputs, and its accepted count never exceeds `L_ACC`.
- R2: If r valid inputs target an output, exactly min(r, `L_ACC`) of them are granted. That output's accepted count equals the number of inputs granted to it.
- R3: A requesting input that is not selected sees its grant low in that slot, which tells it to hold its cell. A requester refused in one slot is granted in a later slot once it is reached in round-robin order.
- R4: An input with its valid low is never granted, and its destination field has no effect on any pointer.
- R5: Each output scans the inputs upward from its pointer, wrapping from N_IN-1 to 0. After a slot with at least one grant, the pointer moves to one past the last input granted. After a slot with no grant to that output, the pointer does not move. All pointers reset to input 0.
- R6: The lane of a granted input is its rank among that output's grants in scan order, with the first input reached getting lane 0. The lane field `lane_o[i*LANE_W +: LANE_W]` is 0 for an input that is not granted.
- R7: Grants, lanes and counts appear in the cycle after the clock edge where `slot_i` is high, and last one cycle. When `slot_i` is low, all of them are zero in the next cycle.
- R8: After reset, all grants, lanes and counts are zero.
- R9: Outputs are arbitrated independently, each with its own pointer. Input i's destination is `req_dest_i[i*DEST_W +: DEST_W]`, and output o's count is `accept_cnt_o[o*CNT_W +: CNT_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_i | input | 1 | Slot strobe; arbitration happens on edges where it is high |
| req_valid_i | input | N_IN | Head-of-line cell present, per input |
| req_dest_i | input | N_IN*DEST_W | Destination output per input |
| grant_o | output | N_IN | Cell accepted, per input |
| lane_o | output | N_IN*LANE_W | Output buffer write port per input |
| accept_cnt_o | output | N_OUT*CNT_W | Cells accepted per output |

## Verification
The bench oversubscribes one output over two slots in a row. A design that does not advance the pointer past the last winner would grant the same two inputs again, and one that drops refused cells would never grant the others. It places the pointer so that the scan wraps past the top input. A design that numbered lanes by input index instead of scan order would give swapped lanes. It also raises a destination with valid low, strobes with valid high but no slot, and mixes two outputs in one slot, to catch stray grants, results without a slot strobe, and pointers shared across outputs.

// File: rtl/sw_arb_pkg.sv
package sw_arb_pkg;
    function automatic int safe_clog2(input int v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction
endpackage

// File: rtl/sw_arb_req_dec.sv
module sw_arb_req_dec #(
    parameter int N_IN   = 4,
    parameter int N_OUT  = 4,
    parameter int DEST_W = 2
) (
    input  logic [N_IN-1:0]        valid_i,
    input  logic [N_IN*DEST_W-1:0] dest_i,
    output logic [N_IN-1:0]        mask_o [N_OUT]
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        always_comb begin
            for (int i = 0; i < N_IN; i++) begin
                mask_o[o][i] = valid_i[i] &&
                    (int'(dest_i[i*DEST_W +: DEST_W]) == o);
            end
        end
    end
endmodule

// File: rtl/sw_arb_sel.sv
module sw_arb_sel #(
    parameter int N_IN   = 4,
    parameter int L_ACC  = 2,
    parameter int PTR_W  = 2,
    parameter int LANE_W = 1,
    parameter int CNT_W  = 2
) (
    input  logic [N_IN-1:0]        req_i,
    input  logic [PTR_W-1:0]       ptr_i,
    output logic [N_IN-1:0]        grant_o,
    output logic [N_IN*LANE_W-1:0] lane_o,
    output logic [CNT_W-1:0]       cnt_o,
    output logic [PTR_W-1:0]       ptr_o,
    output logic                   any_o
);
    always_comb begin
        int taken;
        int last;
        int idx;
        grant_o = '0;
        lane_o  = '0;
        taken   = 0;
        last    = 0;
        for (int k = 0; k < N_IN; k++) begin
            idx = int'(ptr_i) + k;
            if (idx >= N_IN) idx = idx - N_IN;
            if (req_i[idx] && taken < L_ACC) begin
                grant_o[idx] = 1'b1;
                lane_o[idx*LANE_W +: LANE_W] = LANE_W'(taken);
                taken = taken + 1;
                last  = idx;
            end
        end
        any_o = (taken != 0);
        cnt_o = CNT_W'(taken);
        if (taken != 0)
            ptr_o = (last + 1 >= N_IN) ? '0 : PTR_W'(last + 1);
        else
            ptr_o = ptr_i;
    end
endmodule

// File: rtl/sw_arb_top.sv
module sw_arb_top
    import sw_arb_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_OUT  = 4,
    parameter int L_ACC  = 2,
    parameter int DEST_W = safe_clog2(N_OUT),
    parameter int LANE_W = safe_clog2(L_ACC),
    parameter int CNT_W  = $clog2(L_ACC + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   slot_i,
    input  logic [N_IN-1:0]        req_valid_i,
    input  logic [N_IN*DEST_W-1:0] req_dest_i,
    output logic [N_IN-1:0]        grant_o,
    output logic [N_IN*LANE_W-1:0] lane_o,
    output logic [N_OUT*CNT_W-1:0] accept_cnt_o
);
    localparam int PTR_W = safe_clog2(N_IN);

    typedef struct packed {
        logic [N_IN-1:0]        grant;
        logic [N_IN*LANE_W-1:0] lane;
        logic [N_OUT*CNT_W-1:0] cnt;
        logic [N_OUT*PTR_W-1:0] ptr;
    } state_t;

    state_t st_d, st_q;

    logic [N_IN-1:0]        mask   [N_OUT];
    logic [N_IN-1:0]        s_gnt  [N_OUT];
    logic [N_IN*LANE_W-1:0] s_lane [N_OUT];
    logic [CNT_W-1:0]       s_cnt  [N_OUT];
    logic [PTR_W-1:0]       s_ptr  [N_OUT];
    logic [N_OUT-1:0]       s_any;

    sw_arb_req_dec #(.N_IN(N_IN), .N_OUT(N_OUT), .DEST_W(DEST_W)) u_dec (
        .valid_i (req_valid_i),
        .dest_i  (req_dest_i),
        .mask_o  (mask)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_sel
        sw_arb_sel #(
            .N_IN(N_IN), .L_ACC(L_ACC), .PTR_W(PTR_W),
            .LANE_W(LANE_W), .CNT_W(CNT_W)
        ) u_sel (
            .req_i   (mask[o]),
            .ptr_i   (st_q.ptr[o*PTR_W +: PTR_W]),
            .grant_o (s_gnt[o]),
            .lane_o  (s_lane[o]),
            .cnt_o   (s_cnt[o]),
            .ptr_o   (s_ptr[o]),
            .any_o   (s_any[o])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.grant = '0;
        st_d.lane  = '0;
        st_d.cnt   = '0;
        if (slot_i) begin
            for (int o = 0; o < N_OUT; o++) begin
                st_d.grant = st_d.grant | s_gnt[o];
                st_d.lane  = st_d.lane  | s_lane[o];
                st_d.cnt[o*CNT_W +: CNT_W] = s_cnt[o];
                if (s_any[o]) st_d.ptr[o*PTR_W +: PTR_W] = s_ptr[o];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_o      = st_q.grant;
    assign lane_o       = st_q.lane;
    assign accept_cnt_o = st_q.cnt;
endmodule

// File: rtl/sw_arb_chk.sv
module sw_arb_chk #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    parameter int L_ACC = 2,
    parameter int CNT_W = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   slot_i,
    input logic [N_IN-1:0]        req_valid_i,
    input logic [N_IN-1:0]        grant_o,
    input logic [N_OUT*CNT_W-1:0] accept_cnt_o
);
    int cnt_sum;
    always_comb begin
        cnt_sum = 0;
        for (int o = 0; o < N_OUT; o++)
            cnt_sum = cnt_sum + int'(accept_cnt_o[o*CNT_W +: CNT_W]);
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_cnt
        a_r1_cnt_limit: assert property (@(posedge clk) disable iff (!rst_n)
            int'(accept_cnt_o[o*CNT_W +: CNT_W]) <= L_ACC);
    end

    a_r2_cnt_matches_grants: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) == cnt_sum);

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        a_r4_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
            grant_o[i] |-> $past(req_valid_i[i]) && $past(slot_i));
    end

    a_r7_idle_without_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!slot_i) |-> (grant_o == '0) && (cnt_sum == 0));
endmodule

bind sw_arb_top sw_arb_chk #(
    .N_IN(N_IN), .N_OUT(N_OUT), .L_ACC(L_ACC), .CNT_W(CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_i       (slot_i),
    .req_valid_i  (req_valid_i),
    .grant_o      (grant_o),
    .accept_cnt_o (accept_cnt_o)
);

// File: tb/sw_arb_top_tb.sv
module sw_arb_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot = 1'b0;
    logic [3:0] valid = '0;
    logic [7:0] dest = '0;
    logic [3:0] grant;
    logic [3:0] lane;
    logic [7:0] cnt;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sw_arb_top u_dut (
        .clk(clk), .rst_n(rst_n), .slot_i(slot),
        .req_valid_i(valid), .req_dest_i(dest),
        .grant_o(grant), .lane_o(lane), .accept_cnt_o(cnt)
    );

    task automatic chk(input string req, input logic [3:0] eg,
                       input logic [3:0] el, input logic [7:0] ec);
        checks++;
        if (grant !== eg || lane !== el || cnt !== ec) begin
            errors++;
            $display("FAIL %s grant=%b lane=%b cnt=%h expected grant=%b lane=%b cnt=%h",
                     req, grant, lane, cnt, eg, el, ec);
        end
    endtask

    // drive at negedge, register at posedge, sample at following negedge
    task automatic run_slot(input logic s, input logic [3:0] v, input logic [7:0] d);
        @(negedge clk);
        slot = s; valid = v; dest = d;
        @(negedge clk);
        slot = 1'b0; valid = '0; dest = '0;
    endtask

    task automatic t_reset();
        chk("R8 reset", 4'b0000, 4'b0000, 8'h00);
    endtask

    task automatic t_oversubscribe();
        run_slot(1'b1, 4'b1111, 8'h00);
        chk("R1 R2 R5 first two from ptr 0", 4'b0011, 4'b0010, 8'h02);
        run_slot(1'b1, 4'b1111, 8'h00);
        chk("R3 R5 held cells granted next", 4'b1100, 4'b1000, 8'h02);
    endtask

    task automatic t_invalid();
        run_slot(1'b1, 4'b0111, 8'h00);
        chk("R3 R4 invalid never granted", 4'b0011, 4'b0010, 8'h02);
    endtask

    task automatic t_two_outputs();
        run_slot(1'b1, 4'b1111, 8'h50);
        chk("R9 R2 independent outputs", 4'b1111, 4'b1010, 8'h0A);
    endtask

    task automatic t_wrap_lane();
        run_slot(1'b1, 4'b1010, 8'h00);
        chk("R6 lane order follows wrap", 4'b1010, 4'b0010, 8'h02);
    endtask

    task automatic t_no_slot();
        run_slot(1'b0, 4'b1111, 8'h00);
        chk("R7 nothing without slot", 4'b0000, 4'b0000, 8'h00);
    endtask

    task automatic t_single_and_pulse();
        run_slot(1'b1, 4'b0100, 8'h30);
        chk("R2 R6 single requester lane 0", 4'b0100, 4'b0000, 8'h40);
        @(negedge clk);
        chk("R7 one cycle pulse", 4'b0000, 4'b0000, 8'h00);
        run_slot(1'b1, 4'b0111, 8'h3F);
        chk("R5 ptr past last grant, R3 input 2 held", 4'b0011, 4'b0010, 8'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oversubscribe();
        t_invalid();
        t_two_outputs();
        t_wrap_lane();
        t_no_slot();
        t_single_and_pulse();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule